// File: doc/BRIEF.md
# Brown-out Detect Reset Controller

This block turns the raw flag of a supply comparator into a filtered, active-low brown-out signal and a chip reset. The low-supply flag and the power-on-threshold flag come in asynchronously. Each passes through a two-flop synchronizer. The low-supply flag then goes through a glitch filter, and a brown-out is declared only when that filter runs out. A brown-out, or a supply that stays under the power-on threshold long enough, pulls the reset output low. The reset output then stays low until both flags read clear.

Detection has three states: off, blanked or active. After every reset release, detection stays blanked for an activation delay. Software can turn detection off through a small write port. When software turns it back on, detection waits out a separate, shorter delay. Any reset turns detection back on, whatever software last wrote. A status word reports the enable bit, whether detection is active, and a sticky flag that records that a brown-out happened. The sticky flag survives the reset that the brown-out itself causes.

Top module: `bod_reset_ctrl`

## Requirements
- R1: With detection active, `bod_n_o` falls on the (ASSERT_CYC+3)-th rising edge after `vdd_low_i` rises and stays high. The count is two synchronizer stages plus ASSERT_CYC+1 consecutive low samples.
- R2: A `vdd_low_i` pulse lasting ASSERT_CYC cycles or fewer leaves `bod_n_o`, `rst_n_o` and the sticky flag unchanged. It also clears the filter count, so the next pulse starts from zero.
- R3: A brown-out drives `rst_n_o` low on the same edge that `bod_n_o` falls. `bod_n_o` stays low for exactly one cycle.
- R4: While in reset, `rst_n_o` stays low as long as either input flag is set. It rises on the third edge after both flags clear.
- R5: Outside reset, a `por_low_i` level that holds for POR_CYC consecutive synchronized samples pulls `rst_n_o` low. That happens on edge POR_CYC+2 after the input rises, and `bod_n_o` stays high.
- R6: During reset the enable bit is forced to 1 and detection is not active. Writes to enable bit 0 while in reset are ignored.
- R7: After `rst_n_o` rises, the active flag goes to 1 exactly ACT_CYC edges later.
- R8: Writing `wr_data_i[0]`=0 outside reset clears the enable bit and the active flag. While disabled, a held low-supply flag changes neither `bod_n_o` nor `rst_n_o`.
- R9: Writing `wr_data_i[0]`=1 while disabled sets the enable bit. Active then follows ENA_CYC edges after the write edge. Writing 1 while already enabled does not restart blanking.
- R10: `status_o` bit 0 is the enable bit, bit 1 is the active flag and bit 2 is the sticky brown-out flag. The sticky flag is set by a brown-out and cleared by a write with `wr_data_i[1]`=1. Only `arst_n` clears it otherwise.
- R11: `bod_n_o` is high whenever detection was not active in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| arst_n | input | 1 | Asynchronous cold-start reset, active low |
| vdd_low_i | input | 1 | Asynchronous comparator flag: supply under the brown-out level |
| por_low_i | input | 1 | Asynchronous comparator flag: supply under the power-on level |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 2 | Bit 0: detection enable; bit 1: write 1 to clear the sticky flag |
| bod_n_o | output | 1 | Filtered brown-out indication, active low |
| rst_n_o | output | 1 | Chip reset, active low |
| status_o | output | 3 | {sticky brown-out, detection active, enable} |

## Verification
The assertions assume that the comparator flags are levels which hold for at least a few cycles, so that what the synchronizer outputs matches what was driven. They also assume that the write strobe is a single-cycle pulse. The bench changes every asynchronous input and write strobe on the falling clock edge. Each level is held for a whole number of cycles, and each write lasts exactly one cycle. The delay counts in the requirements can therefore be checked down to the edge.

// File: rtl/bod_pkg.sv
package bod_pkg;

    typedef enum logic [1:0] {
        DET_OFF    = 2'd0,
        DET_BLANK  = 2'd1,
        DET_ACTIVE = 2'd2
    } det_state_e;

    localparam int unsigned STS_EN     = 0;
    localparam int unsigned STS_ACTIVE = 1;
    localparam int unsigned STS_STICKY = 2;
    localparam int unsigned STS_W      = 3;

    localparam int unsigned WR_EN_BIT  = 0;
    localparam int unsigned WR_CLR_BIT = 1;
    localparam int unsigned WR_W       = 2;

endpackage

// File: rtl/bod_sync.sv
module bod_sync #(
    parameter int unsigned W       = 1,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s1_d;
    logic [W-1:0] s2_q, s2_d;

    always_comb begin
        s1_d = d_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            s1_q <= {W{RST_VAL}};
            s2_q <= {W{RST_VAL}};
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/bod_persist.sv
module bod_persist #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic en_i,
    input  logic lvl_i,
    output logic fire_o
);
    localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = '0;
        if (en_i && lvl_i) begin
            cnt_d = (cnt_q == LIM) ? cnt_q : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign fire_o = en_i && lvl_i && (cnt_q == LIM);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!arst_n)
        cnt_q <= LIM);

    // R2
    clear_on_gap_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !(en_i && lvl_i) |=> cnt_q == '0);
endmodule

// File: rtl/bod_reset_ctrl.sv
module bod_reset_ctrl
    import bod_pkg::*;
#(
    parameter int unsigned ASSERT_CYC = 8,
    parameter int unsigned ACT_CYC    = 12,
    parameter int unsigned ENA_CYC    = 5,
    parameter int unsigned POR_CYC    = 4
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              vdd_low_i,
    input  logic              por_low_i,
    input  logic              wr_en_i,
    input  logic [WR_W-1:0]   wr_data_i,
    output logic              bod_n_o,
    output logic              rst_n_o,
    output logic [STS_W-1:0]  status_o
);
    localparam int unsigned BMAX = (ACT_CYC > ENA_CYC) ? ACT_CYC : ENA_CYC;
    localparam int unsigned BW   = (BMAX < 2) ? 1 : $clog2(BMAX);
    localparam logic [BW-1:0] ACT_LAST = BW'(ACT_CYC - 1);
    localparam logic [BW-1:0] ENA_LAST = BW'(ENA_CYC - 1);

    typedef struct packed {
        logic          rst;
        logic          bod;
        logic          en;
        logic          ben;
        logic          sticky;
        det_state_e    st;
        logic [BW-1:0] bcnt;
    } ctl_t;

    ctl_t q, d;
    logic low_s, por_s;
    logic flt_fire, por_fire;
    logic [BW-1:0] lim;

    bod_sync #(.W(2), .RST_VAL(1'b1)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d_i    ({por_low_i, vdd_low_i}),
        .q_o    ({por_s, low_s})
    );

    bod_persist #(.LIMIT(ASSERT_CYC)) u_filter (
        .clk    (clk),
        .arst_n (arst_n),
        .en_i   (!q.rst && (q.st == DET_ACTIVE)),
        .lvl_i  (low_s),
        .fire_o (flt_fire)
    );

    bod_persist #(.LIMIT(POR_CYC - 1)) u_por (
        .clk    (clk),
        .arst_n (arst_n),
        .en_i   (!q.rst),
        .lvl_i  (por_s),
        .fire_o (por_fire)
    );

    always_comb begin
        d   = q;
        lim = q.ben ? ENA_LAST : ACT_LAST;
        if (q.rst) begin
            d.rst  = low_s || por_s;
            d.bod  = 1'b0;
            d.en   = 1'b1;
            d.ben  = 1'b0;
            d.st   = DET_BLANK;
            d.bcnt = '0;
        end else begin
            d.bod = flt_fire;
            if (flt_fire || por_fire) begin
                d.rst  = 1'b1;
                d.en   = 1'b1;
                d.ben  = 1'b0;
                d.st   = DET_BLANK;
                d.bcnt = '0;
            end else begin
                if (q.st == DET_BLANK) begin
                    if (q.bcnt == lim) begin
                        d.st   = DET_ACTIVE;
                        d.bcnt = '0;
                    end else begin
                        d.bcnt = q.bcnt + 1'b1;
                    end
                end
                if (wr_en_i && !wr_data_i[WR_EN_BIT] && q.en) begin
                    d.en   = 1'b0;
                    d.st   = DET_OFF;
                    d.bcnt = '0;
                end else if (wr_en_i && wr_data_i[WR_EN_BIT] && !q.en) begin
                    d.en   = 1'b1;
                    d.ben  = 1'b1;
                    d.st   = DET_BLANK;
                    d.bcnt = '0;
                end
            end
        end
        if (!q.rst && flt_fire)                  d.sticky = 1'b1;
        else if (wr_en_i && wr_data_i[WR_CLR_BIT]) d.sticky = 1'b0;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            q.rst    <= 1'b1;
            q.bod    <= 1'b0;
            q.en     <= 1'b1;
            q.ben    <= 1'b0;
            q.sticky <= 1'b0;
            q.st     <= DET_BLANK;
            q.bcnt   <= '0;
        end else begin
            q <= d;
        end
    end

    assign bod_n_o  = !q.bod;
    assign rst_n_o  = !q.rst;
    assign status_o = {q.sticky, (q.st == DET_ACTIVE), q.en};

    // R3
    bod_implies_rst_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !bod_n_o |-> !rst_n_o);

    // R3
    bod_single_pulse_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !bod_n_o |=> bod_n_o);

    // R1
    bod_needs_low_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(bod_n_o) |-> $past(low_s));

    // R4
    release_when_safe_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_n_o) |-> $past(!low_s && !por_s));

    // R6
    reset_forces_en_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !rst_n_o |=> status_o[STS_EN]);

    // R6
    active_out_of_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
        status_o[STS_ACTIVE] |-> rst_n_o);

    // R11
    inactive_bod_high_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !status_o[STS_ACTIVE] |=> bod_n_o);

    // R8
    off_not_active_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !status_o[STS_EN] |-> !status_o[STS_ACTIVE]);
endmodule

// File: tb/bod_reset_ctrl_tb.sv
module bod_reset_ctrl_tb;
    localparam int unsigned N   = 8;
    localparam int unsigned ACT = 12;
    localparam int unsigned ENA = 5;
    localparam int unsigned POR = 4;

    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic       vdd_low = 1'b0;
    logic       por_low = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_data = 2'b00;
    logic       bod_n, rst_n;
    logic [2:0] status;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    bod_reset_ctrl #(
        .ASSERT_CYC (N),
        .ACT_CYC    (ACT),
        .ENA_CYC    (ENA),
        .POR_CYC    (POR)
    ) u_dut (
        .clk       (clk),
        .arst_n    (arst_n),
        .vdd_low_i (vdd_low),
        .por_low_i (por_low),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .bod_n_o   (bod_n),
        .rst_n_o   (rst_n),
        .status_o  (status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int unsigned k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 2'b00;
    endtask

    task automatic t_reset;
        step(3);
        chk("R6 reset rst_n", rst_n, 0);
        chk("R11 reset bod_n", bod_n, 1);
        chk("R10 reset status", status, 3'b001);
    endtask

    task automatic t_startup;
        arst_n = 1'b1;
        for (int i = 0; i < 20 && !rst_n; i++) @(negedge clk);
        chk("R4 startup release", rst_n, 1);
        step(ACT - 1);
        chk("R7 blank before act", status[1], 0);
        step(1);
        chk("R7 active after act", status[1], 1);
        chk("R6 enable after startup", status[0], 1);
    endtask

    task automatic t_glitch;
        logic seen_low = 1'b0;
        vdd_low = 1'b1;
        step(N);
        vdd_low = 1'b0;
        for (int i = 0; i < N + 6; i++) begin
            step(1);
            if (!bod_n || !rst_n) seen_low = 1'b1;
        end
        chk("R2 glitch ignored", seen_low, 0);
        chk("R2 sticky unchanged", status[2], 0);
        vdd_low = 1'b1;
        step(N);
        vdd_low = 1'b0;
        step(N + 6);
        chk("R2 counter cleared", {rst_n, bod_n}, 2'b11);
    endtask

    task automatic t_brownout;
        vdd_low = 1'b1;
        step(N + 2);
        chk("R1 bod_n before expiry", bod_n, 1);
        step(1);
        chk("R1 bod_n at expiry", bod_n, 0);
        chk("R3 rst_n with bod", rst_n, 0);
        chk("R10 sticky set", status[2], 1);
        step(1);
        chk("R3 bod one cycle", bod_n, 1);
        wr(2'b00);
        chk("R6 write in reset ignored", status[0], 1);
        step(5);
        chk("R4 hold while low", rst_n, 0);
        vdd_low = 1'b0;
        step(2);
        chk("R4 not yet released", rst_n, 0);
        step(1);
        chk("R4 released", rst_n, 1);
        step(ACT - 1);
        chk("R7 blank after brownout", status[1], 0);
        step(1);
        chk("R7 active after brownout", status[1], 1);
        chk("R10 sticky survives reset", status[2], 1);
    endtask

    task automatic t_sticky_clear;
        wr(2'b11);
        chk("R10 sticky cleared", status, 3'b011);
        chk("R9 enable rewrite no restart", status[1], 1);
    endtask

    task automatic t_disable;
        logic seen_low = 1'b0;
        wr(2'b00);
        chk("R8 disabled status", status[1:0], 2'b00);
        vdd_low = 1'b1;
        for (int i = 0; i < 3 * N + 6; i++) begin
            step(1);
            if (!bod_n || !rst_n) seen_low = 1'b1;
        end
        chk("R8 low ignored while off", seen_low, 0);
        chk("R8 sticky untouched", status[2], 0);
        vdd_low = 1'b0;
        step(3);
    endtask

    task automatic t_reenable;
        wr(2'b01);
        chk("R9 enable set", status[0], 1);
        step(ENA - 1);
        chk("R9 blank before ena", status[1], 0);
        step(1);
        chk("R9 active after ena", status[1], 1);
    endtask

    task automatic t_por;
        wr(2'b00);
        chk("R8 off before por", status[0], 0);
        por_low = 1'b1;
        step(POR + 1);
        chk("R5 rst before por expiry", rst_n, 1);
        step(1);
        chk("R5 rst at por expiry", rst_n, 0);
        chk("R5 bod_n high on por", bod_n, 1);
        chk("R6 enable forced on", status[1:0], 2'b01);
        por_low = 1'b0;
        step(3);
        chk("R4 release after por", rst_n, 1);
        chk("R10 sticky not set by por", status[2], 0);
        step(ACT - 1);
        chk("R7 blank after por", status[1], 0);
        step(1);
        chk("R7 active after por", status[1], 1);
    endtask

    initial begin
        t_reset();
        t_startup();
        t_glitch();
        t_brownout();
        t_sticky_clear();
        t_disable();
        t_reenable();
        t_por();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule